// File: doc/BRIEF.md
# DMA Controller Host Register File

This block is the processor-facing register file of a four-channel DMA controller. A host reaches it through an 8-bit data port and a 4-bit register offset, one access per clock. Each channel keeps a 16-bit address and a 16-bit transfer count, and each of these has a base copy and a current copy. A narrow port can only carry a 16-bit value as two byte accesses, so a single byte pointer shared by every channel chooses which half the next access reaches. Command, request, mask, mode and status registers complete the set. Mask, mode and request writes carry the target channel inside the data byte, not in the offset.

The transfer engine reads the base values, mask bits, mode fields, command byte and request bits from dedicated outputs. It writes updated current address and count values back through a load port and reports terminal count events. The host reads the current copies back at the channel offsets, and reads the latched terminal counts and the live request lines at the status offset.

Top module: `dmac_regfile`

## Requirements
- R1: After a synchronous active-low reset all four mask bits are 1. Command, request, status, mode, base and current values are 0, and the byte pointer selects the low byte.
- R2: The address register of channel n is at offset 2n. A write loads the selected byte (low when the pointer is low, high when it is high) into both the base and the current copy. A read returns the selected byte of the current copy.
- R3: The count register of channel n is at offset 2n+1. Writes and reads follow the same byte rule as the address register.
- R4: One byte pointer is shared by all eight channel offsets. It toggles after every read or write at offsets 0 to 7, and any write to offset 12 forces it to the low-byte state.
- R5: A write to offset 10 sets (data bit 2 = 1) or clears (bit 2 = 0) the mask bit of the channel chosen by data bits [1:0].
- R6: A write to offset 11 stores data bits [7:2] as the 6-bit mode of the channel chosen by bits [1:0]. Data bit 4 drives that channel's auto-initialize output, and bits [7:6] = 11 drive its cascade output. So 0x44 is stored as 0x11, 0x48 as 0x12 and 0xC0 as 0x30.
- R7: A write to offset 14 clears all four mask bits. A write to offset 15 loads all four mask bits from data bits [3:0].
- R8: A write to offset 8 loads the command byte. A read of offset 8 returns status, with bits [7:4] equal to the live request lines and bits [3:0] equal to the latched terminal counts. The read clears the latched bits, except that a terminal count event arriving in the same cycle as the read stays latched.
- R9: A write to offset 9 sets (data bit 2 = 1) or clears the request bit of the channel chosen by data bits [1:0].
- R10: A write to offset 13 is a master clear. It sets all mask bits, clears command, request and latched status, and forces the byte pointer low. Modes, base and current values are kept. A read of offset 13 returns the temporary-data input.
- R11: An engine load writes the current address and count of the selected channel and leaves the base copies alone. When a host byte write reaches the same register of that channel in the same cycle, the host byte wins, the other current byte keeps its value, and the engine value for that register is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe; ignored while wr_en is high |
| reg_off | input | 4 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data; 0 when no read is active |
| eng_ld_i | input | 1 | Engine load of current values |
| eng_ch_i | input | 2 | Channel of the engine load |
| eng_addr_i | input | 16 | Current address from the engine |
| eng_cnt_i | input | 16 | Current count from the engine |
| tc_set_i | input | 4 | Terminal count event per channel |
| dreq_i | input | 4 | Live request lines shown in status |
| temp_i | input | 8 | Temporary data returned at offset 13 |
| mask_o | output | 4 | Channel mask bits |
| cmd_o | output | 8 | Command byte |
| req_o | output | 4 | Request register bits |
| mode_o | output | 24 | Per-channel 6-bit modes, channel n at [6n+5:6n] |
| autoinit_o | output | 4 | Auto-initialize enable per channel |
| cascade_o | output | 4 | Cascade mode per channel |
| base_addr_o | output | 64 | Base addresses, channel n at [16n+15:16n] |
| base_cnt_o | output | 64 | Base counts, channel n at [16n+15:16n] |

## Verification
Two pairs of functions can land in the same cycle. A status read that clears the latched terminal counts can meet a new terminal count event. A host byte write to a channel's address register can meet an engine load of the same channel. The bench raises a terminal count pulse on the same edge as a status read, then reads status twice more: the bit must still be set on the first of these reads and cleared on the second. It also lines up a high-byte address write with an engine load, then reads both current registers back and expects the merged address and the engine's count.

// File: rtl/dmac_regfile_pkg.sv
// Package: shared constants, register offsets and the decoded-access type
// for the DMA host register file. Assumes exactly four channels, because
// the channel offsets 2n/2n+1 fill offsets 0..7.
package dmac_regfile_pkg;

    localparam int NUM_CH  = 4;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int DATA_W  = 8;
    localparam int WORD_W  = 16;
    localparam int OFF_W   = 4;
    localparam int MODE_W  = DATA_W - CH_W;
    localparam int MODE_AI = 4 - CH_W;          // auto-init bit inside stored mode
    localparam int MODE_CS = MODE_W - 2;        // cascade field base inside stored mode

    localparam logic [OFF_W-1:0] OFF_CMD    = 4'd8;
    localparam logic [OFF_W-1:0] OFF_REQ    = 4'd9;
    localparam logic [OFF_W-1:0] OFF_SMASK  = 4'd10;
    localparam logic [OFF_W-1:0] OFF_MODE   = 4'd11;
    localparam logic [OFF_W-1:0] OFF_PCLR   = 4'd12;
    localparam logic [OFF_W-1:0] OFF_MCLR   = 4'd13;
    localparam logic [OFF_W-1:0] OFF_MSKCLR = 4'd14;
    localparam logic [OFF_W-1:0] OFF_MSKALL = 4'd15;

    typedef struct packed {
        logic            chan_wr;
        logic            chan_rd;
        logic            sel_cnt;
        logic [CH_W-1:0] ch;
        logic            cmd_wr;
        logic            stat_rd;
        logic            req_wr;
        logic            smask_wr;
        logic            mode_wr;
        logic            ptr_clr;
        logic            mclr;
        logic            temp_rd;
        logic            mask_clr;
        logic            mask_all;
    } acc_t;

endpackage

// File: rtl/dmac_regfile_decode.sv
// Module: turns the host strobes and the offset into one decoded access.
// Assumes a write and a read in the same cycle are treated as the write only.
module dmac_regfile_decode
    import dmac_regfile_pkg::*;
(
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFF_W-1:0] reg_off,
    output acc_t             acc
);

    logic rd_act;
    logic is_chan;

    assign rd_act  = rd_en && !wr_en;
    assign is_chan = !reg_off[OFF_W-1];

    // Purpose: one-hot style decode of every register action for this cycle.
    always_comb begin
        acc          = '0;
        acc.ch       = reg_off[CH_W:1];
        acc.sel_cnt  = reg_off[0];
        acc.chan_wr  = wr_en  && is_chan;
        acc.chan_rd  = rd_act && is_chan;
        acc.cmd_wr   = wr_en  && (reg_off == OFF_CMD);
        acc.stat_rd  = rd_act && (reg_off == OFF_CMD);
        acc.req_wr   = wr_en  && (reg_off == OFF_REQ);
        acc.smask_wr = wr_en  && (reg_off == OFF_SMASK);
        acc.mode_wr  = wr_en  && (reg_off == OFF_MODE);
        acc.ptr_clr  = wr_en  && (reg_off == OFF_PCLR);
        acc.mclr     = wr_en  && (reg_off == OFF_MCLR);
        acc.temp_rd  = rd_act && (reg_off == OFF_MCLR);
        acc.mask_clr = wr_en  && (reg_off == OFF_MSKCLR);
        acc.mask_all = wr_en  && (reg_off == OFF_MSKALL);
    end

endmodule

// File: rtl/dmac_word_reg.sv
// Module: one 16-bit base/current register pair written a byte at a time.
// Assumes the caller qualifies host_wr with the channel and register select.
// A host byte write takes priority over an engine load in the same cycle.
module dmac_word_reg
    import dmac_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              byte_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_ld,
    input  logic [WORD_W-1:0] eng_val,
    output logic [WORD_W-1:0] base_q,
    output logic [WORD_W-1:0] cur_q
);

    // Purpose: load a host byte into both copies, or an engine value into current.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (host_wr) begin
            if (byte_hi) begin
                base_q[WORD_W-1:DATA_W] <= wdata;
                cur_q[WORD_W-1:DATA_W]  <= wdata;
            end else begin
                base_q[DATA_W-1:0] <= wdata;
                cur_q[DATA_W-1:0]  <= wdata;
            end
        end else if (eng_ld) begin
            cur_q <= eng_val;
        end
    end

endmodule

// File: rtl/dmac_regfile_ctrl.sv
// Module: byte pointer, command, request, mask, mode and latched status.
// Assumes at most one decoded action is active per cycle (offset decode).
module dmac_regfile_ctrl
    import dmac_regfile_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  acc_t                           acc,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NUM_CH-1:0]              tc_set,
    output logic                           byte_hi,
    output logic [DATA_W-1:0]              cmd_q,
    output logic [NUM_CH-1:0]              req_q,
    output logic [NUM_CH-1:0]              mask_q,
    output logic [NUM_CH-1:0][MODE_W-1:0]  mode_q,
    output logic [NUM_CH-1:0]              tc_q
);

    logic [CH_W-1:0] wch;
    assign wch = wdata[CH_W-1:0];

    // Purpose: shared byte pointer, cleared explicitly, toggled per channel access.
    always_ff @(posedge clk) begin
        if (!rst_n)                        byte_hi <= 1'b0;
        else if (acc.ptr_clr || acc.mclr)  byte_hi <= 1'b0;
        else if (acc.chan_wr || acc.chan_rd) byte_hi <= !byte_hi;
    end

    // Purpose: command byte, cleared by master clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          cmd_q <= '0;
        else if (acc.mclr)   cmd_q <= '0;
        else if (acc.cmd_wr) cmd_q <= wdata;
    end

    // Purpose: software request bits, channel chosen inside the data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)          req_q <= '0;
        else if (acc.mclr)   req_q <= '0;
        else if (acc.req_wr) req_q[wch] <= wdata[2];
    end

    // Purpose: mask bits from single, clear-all and write-all accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)              mask_q <= '1;
        else if (acc.mclr)       mask_q <= '1;
        else if (acc.mask_clr)   mask_q <= '0;
        else if (acc.mask_all)   mask_q <= wdata[NUM_CH-1:0];
        else if (acc.smask_wr)   mask_q[wch] <= wdata[2];
    end

    // Purpose: per-channel mode storage, kept across master clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= '0;
        else if (acc.mode_wr) mode_q[wch] <= wdata[DATA_W-1:CH_W];
    end

    // Purpose: sticky terminal counts, cleared by a status read unless newly set.
    always_ff @(posedge clk) begin
        if (!rst_n)         tc_q <= '0;
        else if (acc.mclr)  tc_q <= '0;
        else                tc_q <= (acc.stat_rd ? '0 : tc_q) | tc_set;
    end

endmodule

// File: rtl/dmac_regfile.sv
// Module: top of the DMA host register file. Decodes the host access,
// holds per-channel address/count pairs, the control registers, and drives
// the read mux. Assumes the engine presents complete 16-bit current values.
module dmac_regfile
    import dmac_regfile_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [3:0]                reg_off,
    input  logic [7:0]                wdata,
    output logic [7:0]                rdata,
    input  logic                      eng_ld_i,
    input  logic [1:0]                eng_ch_i,
    input  logic [15:0]               eng_addr_i,
    input  logic [15:0]               eng_cnt_i,
    input  logic [3:0]                tc_set_i,
    input  logic [3:0]                dreq_i,
    input  logic [7:0]                temp_i,
    output logic [3:0]                mask_o,
    output logic [7:0]                cmd_o,
    output logic [3:0]                req_o,
    output logic [23:0]               mode_o,
    output logic [3:0]                autoinit_o,
    output logic [3:0]                cascade_o,
    output logic [63:0]               base_addr_o,
    output logic [63:0]               base_cnt_o
);

    acc_t                          acc;
    logic                          byte_hi;
    logic [NUM_CH-1:0]             tc_q;
    logic [NUM_CH-1:0][MODE_W-1:0] mode_q;
    logic [NUM_CH-1:0][WORD_W-1:0] cur_addr;
    logic [NUM_CH-1:0][WORD_W-1:0] cur_cnt;
    logic [NUM_CH-1:0][WORD_W-1:0] base_addr;
    logic [NUM_CH-1:0][WORD_W-1:0] base_cnt;
    logic [WORD_W-1:0]             rd_word;

    dmac_regfile_decode u_decode (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .reg_off (reg_off),
        .acc     (acc)
    );

    dmac_regfile_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wdata   (wdata),
        .tc_set  (tc_set_i),
        .byte_hi (byte_hi),
        .cmd_q   (cmd_o),
        .req_q   (req_o),
        .mask_q  (mask_o),
        .mode_q  (mode_q),
        .tc_q    (tc_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        logic eng_sel;
        assign sel     = acc.chan_wr && (acc.ch == CH_W'(i));
        assign eng_sel = eng_ld_i && (eng_ch_i == CH_W'(i));

        dmac_word_reg u_addr (
            .clk     (clk),
            .rst_n   (rst_n),
            .host_wr (sel && !acc.sel_cnt),
            .byte_hi (byte_hi),
            .wdata   (wdata),
            .eng_ld  (eng_sel),
            .eng_val (eng_addr_i),
            .base_q  (base_addr[i]),
            .cur_q   (cur_addr[i])
        );

        dmac_word_reg u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .host_wr (sel && acc.sel_cnt),
            .byte_hi (byte_hi),
            .wdata   (wdata),
            .eng_ld  (eng_sel),
            .eng_val (eng_cnt_i),
            .base_q  (base_cnt[i]),
            .cur_q   (cur_cnt[i])
        );

        assign autoinit_o[i] = mode_q[i][MODE_AI];
        assign cascade_o[i]  = &mode_q[i][MODE_W-1:MODE_CS];
    end

    assign mode_o      = mode_q;
    assign base_addr_o = base_addr;
    assign base_cnt_o  = base_cnt;

    // Purpose: pick the current word of the addressed channel register.
    assign rd_word = acc.sel_cnt ? cur_cnt[acc.ch] : cur_addr[acc.ch];

    // Purpose: host read data mux; zero when no read is decoded.
    always_comb begin
        rdata = '0;
        if (acc.chan_rd)      rdata = byte_hi ? rd_word[WORD_W-1:DATA_W] : rd_word[DATA_W-1:0];
        else if (acc.stat_rd) rdata = {dreq_i, tc_q};
        else if (acc.temp_rd) rdata = temp_i;
    end

endmodule

// File: rtl/dmac_regfile_chk.sv
// Module: assertion checker bound to dmac_regfile; observes ports and the
// byte pointer and latched terminal counts. Assumes synchronous active-low reset.
module dmac_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [3:0]  reg_off,
    input logic [1:0]  mode_ch,
    input logic        mode_ai,
    input logic        tc0,
    input logic        eng_ld_i,
    input logic [3:0]  mask_o,
    input logic [7:0]  cmd_o,
    input logic [3:0]  req_o,
    input logic [3:0]  autoinit_o,
    input logic [63:0] base_addr_o,
    input logic        byte_hi,
    input logic [3:0]  tc_q
);

    p_mclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == 4'd13) |=>
            (mask_o == 4'hF && cmd_o == 8'h00 && req_o == 4'h0 && !byte_hi && tc_q == 4'h0));

    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == 4'd14) |=> (mask_o == 4'h0));

    p_ptr_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == 4'd12) |=> !byte_hi);

    p_ptr_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !reg_off[3]) |=> (byte_hi != $past(byte_hi)));

    p_tc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tc0 && !(wr_en && reg_off == 4'd13)) |=> tc_q[0]);

    p_base_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_ld_i && !wr_en) |=> $stable(base_addr_o));

    p_autoinit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == 4'd11) |=> (autoinit_o[$past(mode_ch)] == $past(mode_ai)));

endmodule

bind dmac_regfile dmac_regfile_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .reg_off     (reg_off),
    .mode_ch     (wdata[1:0]),
    .mode_ai     (wdata[4]),
    .tc0         (tc_set_i[0]),
    .eng_ld_i    (eng_ld_i),
    .mask_o      (mask_o),
    .cmd_o       (cmd_o),
    .req_o       (req_o),
    .autoinit_o  (autoinit_o),
    .base_addr_o (base_addr_o),
    .byte_hi     (byte_hi),
    .tc_q        (tc_q)
);

// File: tb/dmac_regfile_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module dmac_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  reg_off = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        eng_ld_i = 1'b0;
    logic [1:0]  eng_ch_i = '0;
    logic [15:0] eng_addr_i = '0;
    logic [15:0] eng_cnt_i = '0;
    logic [3:0]  tc_set_i = '0;
    logic [3:0]  dreq_i = '0;
    logic [7:0]  temp_i = '0;
    logic [3:0]  mask_o;
    logic [7:0]  cmd_o;
    logic [3:0]  req_o;
    logic [23:0] mode_o;
    logic [3:0]  autoinit_o;
    logic [3:0]  cascade_o;
    logic [63:0] base_addr_o;
    logic [63:0] base_cnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dmac_regfile u_dmac_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_off(reg_off), .wdata(wdata), .rdata(rdata),
        .eng_ld_i(eng_ld_i), .eng_ch_i(eng_ch_i), .eng_addr_i(eng_addr_i),
        .eng_cnt_i(eng_cnt_i), .tc_set_i(tc_set_i), .dreq_i(dreq_i),
        .temp_i(temp_i), .mask_o(mask_o), .cmd_o(cmd_o), .req_o(req_o),
        .mode_o(mode_o), .autoinit_o(autoinit_o), .cascade_o(cascade_o),
        .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_off = off; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] off, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_off = off;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_tc(input logic [3:0] v);
        @(negedge clk);
        tc_set_i = v;
        @(negedge clk);
        tc_set_i = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 mask", mask_o, 64'hF);
        chk("R1 cmd/req", {cmd_o, req_o}, 64'h0);
        chk("R1 base", base_addr_o | base_cnt_o, 64'h0);
        chk("R1 mode", mode_o, 64'h0);
        do_rd(4'd8, d);
        chk("R1 status", d, 64'h00);
    endtask

    task automatic t_addr();
        logic [7:0] lo, hi;
        do_wr(4'd12, 8'h00);
        do_wr(4'd2, 8'h34);
        do_wr(4'd2, 8'h12);
        chk("R2 base addr ch1", base_addr_o[31:16], 64'h1234);
        do_rd(4'd2, lo);
        do_rd(4'd2, hi);
        chk("R2 readback", {hi, lo}, 64'h1234);
    endtask

    task automatic t_count();
        logic [7:0] lo, hi;
        do_wr(4'd12, 8'h00);
        do_wr(4'd7, 8'hFF);
        do_wr(4'd7, 8'h0F);
        chk("R3 base cnt ch3", base_cnt_o[63:48], 64'h0FFF);
        do_rd(4'd7, lo);
        do_rd(4'd7, hi);
        chk("R3 readback", {hi, lo}, 64'h0FFF);
    endtask

    task automatic t_shared_ptr();
        do_wr(4'd12, 8'h00);
        do_wr(4'd0, 8'h11);
        do_wr(4'd1, 8'h22);
        chk("R4 shared pointer high byte", base_cnt_o[15:0], 64'h2200);
        do_wr(4'd12, 8'h00);
        do_wr(4'd1, 8'h33);
        chk("R4 pointer clear low byte", base_cnt_o[15:0], 64'h2233);
        chk("R4 ch0 addr", base_addr_o[15:0], 64'h0011);
    endtask

    task automatic t_mask();
        do_wr(4'd10, 8'h01);
        chk("R5 clear ch1", mask_o, 64'hD);
        do_wr(4'd10, 8'h02);
        chk("R5 clear ch2", mask_o, 64'h9);
        do_wr(4'd10, 8'h05);
        chk("R5 set ch1", mask_o, 64'hB);
    endtask

    task automatic t_mode();
        do_wr(4'd11, 8'h45);
        chk("R6 mode ch1 0x44", mode_o[11:6], 64'h11);
        chk("R6 flags ch1", {autoinit_o[1], cascade_o[1]}, 64'h0);
        do_wr(4'd11, 8'h5A);
        chk("R6 mode ch2 0x48+autoinit", mode_o[17:12], 64'h16);
        chk("R6 autoinit ch2", autoinit_o, 64'h4);
        do_wr(4'd11, 8'hC3);
        chk("R6 mode ch3 cascade", mode_o[23:18], 64'h30);
        chk("R6 cascade", cascade_o, 64'h8);
    endtask

    task automatic t_allmask();
        do_wr(4'd14, 8'hFF);
        chk("R7 clear all", mask_o, 64'h0);
        do_wr(4'd15, 8'hF5);
        chk("R7 write all", mask_o, 64'h5);
    endtask

    task automatic t_cmd_req();
        do_wr(4'd8, 8'hA5);
        chk("R8 command", cmd_o, 64'hA5);
        do_wr(4'd9, 8'h06);
        chk("R9 set ch2", req_o, 64'h4);
        do_wr(4'd9, 8'h07);
        chk("R9 set ch3", req_o, 64'hC);
        do_wr(4'd9, 8'h02);
        chk("R9 clear ch2", req_o, 64'h8);
    endtask

    task automatic t_status();
        logic [7:0] d;
        dreq_i = 4'b1010;
        pulse_tc(4'b0010);
        do_rd(4'd8, d);
        chk("R8 status latched", d, 64'hA2);
        do_rd(4'd8, d);
        chk("R8 status cleared by read", d, 64'hA0);
        @(negedge clk);
        rd_en = 1'b1; reg_off = 4'd8; tc_set_i = 4'b0001;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; tc_set_i = '0;
        chk("R8 collision read value", d, 64'hA0);
        do_rd(4'd8, d);
        chk("R8 event kept over read", d, 64'hA1);
        do_rd(4'd8, d);
        chk("R8 cleared afterwards", d, 64'hA0);
        dreq_i = '0;
    endtask

    task automatic t_engine();
        logic [7:0] a0, a1, c0, c1;
        @(negedge clk);
        eng_ld_i = 1'b1; eng_ch_i = 2'd0; eng_addr_i = 16'hBEEF; eng_cnt_i = 16'h0102;
        @(negedge clk);
        eng_ld_i = 1'b0;
        chk("R11 base unchanged", {base_addr_o[15:0], base_cnt_o[15:0]}, 64'h00112233);
        do_wr(4'd12, 8'h00);
        do_rd(4'd0, a0); do_rd(4'd0, a1);
        do_rd(4'd1, c0); do_rd(4'd1, c1);
        chk("R11 current addr", {a1, a0}, 64'hBEEF);
        chk("R11 current cnt", {c1, c0}, 64'h0102);
    endtask

    task automatic t_collision();
        logic [7:0] a0, a1, c0, c1;
        do_wr(4'd12, 8'h00);
        do_wr(4'd4, 8'h34);
        @(negedge clk);
        wr_en = 1'b1; reg_off = 4'd4; wdata = 8'h12;
        eng_ld_i = 1'b1; eng_ch_i = 2'd2; eng_addr_i = 16'hAAAA; eng_cnt_i = 16'h5555;
        @(negedge clk);
        wr_en = 1'b0; eng_ld_i = 1'b0;
        chk("R11 collision base", base_addr_o[47:32], 64'h1234);
        do_wr(4'd12, 8'h00);
        do_rd(4'd4, a0); do_rd(4'd4, a1);
        do_rd(4'd5, c0); do_rd(4'd5, c1);
        chk("R11 host wins addr", {a1, a0}, 64'h1234);
        chk("R11 engine count applied", {c1, c0}, 64'h5555);
    endtask

    task automatic t_mclr();
        logic [7:0] d;
        do_wr(4'd12, 8'h00);
        do_wr(4'd6, 8'h77);
        pulse_tc(4'b1000);
        do_wr(4'd13, 8'h00);
        chk("R10 mask set", mask_o, 64'hF);
        chk("R10 cmd/req cleared", {cmd_o, req_o}, 64'h0);
        chk("R10 base kept", base_cnt_o[63:48], 64'h0FFF);
        chk("R10 mode kept", mode_o[23:18], 64'h30);
        do_rd(4'd6, d);
        chk("R10 pointer low", d, 64'h77);
        do_rd(4'd8, d);
        chk("R10 status cleared", d, 64'h00);
        temp_i = 8'h5C;
        do_rd(4'd13, d);
        chk("R10 temp read", d, 64'h5C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr();
        t_count();
        t_shared_ptr();
        t_mask();
        t_mode();
        t_allmask();
        t_cmd_req();
        t_status();
        t_engine();
        t_collision();
        t_mclr();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule